// File: doc/BRIEF.md
# Envelope-Indexed Complex-Gain Predistorter

This block sits in a transmit chain between the digital upconverter and the DAC. Each accepted baseband I/Q sample has its envelope magnitude, the integer square root of I² + Q², computed by a pipelined root unit. The magnitude is scaled into one of a fixed number of amplitude buckets. The bucket selects a complex gain word from a table, and the sample is multiplied by that word with a full complex multiply. The rounded and saturated product leaves the block as the predistorted sample. Each table entry holds the inverse of the amplifier's gain compression and phase shift at that envelope level, so the amplifier output comes out linear.

An external adaptation engine rewrites table entries through a single write port while the stream keeps running. The stream is never stalled. Next to every output sample the block presents the original input sample and the bucket it used, both aligned with the output. Feedback logic can use them to compare the reference against the amplifier's measured output.

Top module: `lut_predistorter`

## Requirements
- R1: Reset clears `out_valid` and loads every one of the 100 table entries with unity gain. In the gain format (signed 12-bit, 10 fraction bits) unity is real 1024, imaginary 0. A sample sent after reset with no table write therefore comes out unchanged.
- R2: The bucket is min(floor(m × 100 / 32768), 99), where m = floor(sqrt(I² + Q²)). `ref_addr` shows the bucket used for the sample currently at the output.
- R3: With table entry (gr, gi), the output is out_i = (I·gr − Q·gi + 512) >>> 10 and out_q = (I·gi + Q·gr + 512) >>> 10. Both are computed at full precision, with rounding half toward positive infinity.
- R4: A result outside the signed 16-bit range is clamped to 32767 or −32768 and never wraps.
- R5: Every input accepted with `in_valid` gives exactly one output with `out_valid` high 19 clock cycles later. Gaps in the input stream are kept in the output stream.
- R6: While `out_valid` is high, `ref_i` and `ref_q` equal the input sample that produced the output.
- R7: A sample reads the table at the 18th rising edge after the edge that accepted it. A table write is seen by every table read on a later edge. A write to the same entry on the very edge of the read is not seen: that sample uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 7 | Table entry to write (0..99) |
| wr_gain_r | input | 12 | Real part of gain written, signed, 10 fraction bits |
| wr_gain_i | input | 12 | Imaginary part of gain written, signed, 10 fraction bits |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Predistorted in-phase sample |
| out_q | output | 16 | Predistorted quadrature sample |
| ref_i | output | 16 | Input in-phase sample aligned with output |
| ref_q | output | 16 | Input quadrature sample aligned with output |
| ref_addr | output | 7 | Bucket used for the current output |

## Verification
The hardest situation to reach is a table write that lands on the same clock edge as the read of that entry by a sample in flight, and then one that lands a single edge earlier. From the ports this needs exact edge counting across the whole root pipeline. The stimulus sends a lone sample whose magnitude maps to a chosen bucket, counts edges from acceptance, and fires the write at edge 18 and then at edge 17. It expects the old gain in the first case and the new gain in the second. Constrained random streams with gaps and random tables cover the arithmetic. Directed extremes hit the bucket clamp and both saturation rails.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int LPD_DW      = 16;
  localparam int LPD_GW      = 12;
  localparam int LPD_GF      = 10;
  localparam int LPD_ENTRIES = 100;

  // edge (after acceptance) at which a sample reads the table: squares, root stages, bucket
  function automatic int lpd_read_stage(input int dw);
    return dw + 2;
  endfunction
endpackage

// File: rtl/lpd_isqrt.sv
module lpd_isqrt #(
  parameter int RW = 16,
  localparam int XW = 2 * RW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] in_x,
  output logic          out_valid,
  output logic [RW-1:0] out_root
);
  logic [XW-1:0] x_q  [0:RW-1];
  logic [RW-1:0] r_q  [0:RW-1];
  logic          v_q  [0:RW-1];
  logic [XW-1:0] xs   [0:RW-1];
  logic [RW-1:0] rs   [0:RW-1];
  logic          vs   [0:RW-1];
  logic [RW-1:0] trial[0:RW-1];
  logic          keep [0:RW-1];

  always_comb begin
    xs[0] = in_x;
    rs[0] = '0;
    vs[0] = in_valid;
    for (int s = 1; s < RW; s++) begin
      xs[s] = x_q[s-1];
      rs[s] = r_q[s-1];
      vs[s] = v_q[s-1];
    end
    for (int s = 0; s < RW; s++) begin
      trial[s] = rs[s] | ({{(RW-1){1'b0}}, 1'b1} << (RW - 1 - s));
      keep[s]  = (XW'(trial[s]) * XW'(trial[s])) <= xs[s];
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < RW; s++) begin
      x_q[s] <= xs[s];
      r_q[s] <= keep[s] ? trial[s] : rs[s];
      v_q[s] <= rst ? 1'b0 : vs[s];
    end
  end

  assign out_valid = v_q[RW-1];
  assign out_root  = r_q[RW-1];

  logic [XW+1:0] chk_lo, chk_hi;
  assign chk_lo = (XW+2)'(out_root) * (XW+2)'(out_root);
  assign chk_hi = ((XW+2)'(out_root) + 1) * ((XW+2)'(out_root) + 1);

  p_root_floor_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (chk_lo <= (XW+2)'(x_q[RW-1])) && (chk_hi > (XW+2)'(x_q[RW-1])));
endmodule

// File: rtl/lpd_gain_table.sv
module lpd_gain_table #(
  parameter int GW      = 12,
  parameter int GF      = 10,
  parameter int ENTRIES = 100,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [GW-1:0] wr_g_r,
  input  logic signed [GW-1:0] wr_g_i,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic                 rd_valid,
  output logic signed [GW-1:0] rd_g_r,
  output logic signed [GW-1:0] rd_g_i
);
  localparam logic [2*GW-1:0] UNITY = {GW'(0), GW'(1 << GF)};

  logic [2*GW-1:0] mem [0:ENTRIES-1];
  logic [2*GW-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= UNITY;
      rd_valid <= 1'b0;
      rd_word  <= UNITY;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_word <= mem[rd_addr];   // old contents on a same-edge write
      if (wr_en && (int'(wr_addr) < ENTRIES)) mem[wr_addr] <= {wr_g_i, wr_g_r};
    end
  end

  assign rd_g_r = rd_word[GW-1:0];
  assign rd_g_i = rd_word[2*GW-1:GW];

  p_read_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: rtl/lpd_cmul.sv
module lpd_cmul #(
  parameter int DW = 16,
  parameter int GW = 12,
  parameter int GF = 10,
  parameter int AW = 7,
  localparam int PW = DW + GW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] d_i,
  input  logic signed [DW-1:0] d_q,
  input  logic signed [GW-1:0] g_r,
  input  logic signed [GW-1:0] g_i,
  input  logic [AW-1:0]        tag_addr,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic signed [DW-1:0] ref_i,
  output logic signed [DW-1:0] ref_q,
  output logic [AW-1:0]        ref_addr
);
  localparam logic signed [PW-1:0] HALF = PW'(1) << (GF - 1);
  localparam logic signed [PW-1:0] HI   = (PW'(1) << (DW - 1)) - 1;
  localparam logic signed [PW-1:0] LO   = ~HI;

  function automatic logic signed [DW-1:0] fit(input logic signed [PW-1:0] v);
    if (v > HI)      return HI[DW-1:0];
    else if (v < LO) return LO[DW-1:0];
    else             return v[DW-1:0];
  endfunction

  logic signed [DW+GW-1:0] p_ir, p_qi, p_ii, p_qr;
  logic signed [PW-1:0]    acc_r, acc_q, rnd_r, rnd_q, sh_r, sh_q;

  always_comb begin
    p_ir  = d_i * g_r;
    p_qi  = d_q * g_i;
    p_ii  = d_i * g_i;
    p_qr  = d_q * g_r;
    acc_r = {p_ir[DW+GW-1], p_ir} - {p_qi[DW+GW-1], p_qi};
    acc_q = {p_ii[DW+GW-1], p_ii} + {p_qr[DW+GW-1], p_qr};
    rnd_r = acc_r + HALF;
    rnd_q = acc_q + HALF;
    sh_r  = rnd_r >>> GF;
    sh_q  = rnd_q >>> GF;
  end

  always_ff @(posedge clk) begin
    out_valid <= rst ? 1'b0 : in_valid;
    out_i     <= fit(sh_r);
    out_q     <= fit(sh_q);
    ref_i     <= d_i;
    ref_q     <= d_q;
    ref_addr  <= tag_addr;
  end

  p_valid_follow_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  p_unity_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && g_r == GW'(1 << GF) && g_i == '0) |=>
      (out_i == $past(d_i)) && (out_q == $past(d_q)));
endmodule

// File: rtl/lut_predistorter.sv
module lut_predistorter #(
  parameter int DW      = lpd_pkg::LPD_DW,
  parameter int GW      = lpd_pkg::LPD_GW,
  parameter int GF      = lpd_pkg::LPD_GF,
  parameter int ENTRIES = lpd_pkg::LPD_ENTRIES,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [GW-1:0] wr_gain_r,
  input  logic signed [GW-1:0] wr_gain_i,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic signed [DW-1:0] ref_i,
  output logic signed [DW-1:0] ref_q,
  output logic [AW-1:0]        ref_addr
);
  localparam int RD = lpd_pkg::lpd_read_stage(DW);
  localparam int SW = DW + AW;

  // stage 1: energy
  logic signed [2*DW-1:0] pwr_i, pwr_q;
  logic [2*DW-1:0]        energy_q;
  logic                   energy_v;
  assign pwr_i = in_i * in_i;
  assign pwr_q = in_q * in_q;

  always_ff @(posedge clk) begin
    energy_v <= rst ? 1'b0 : in_valid;
    energy_q <= $unsigned(pwr_i) + $unsigned(pwr_q);
  end

  // root pipeline
  logic          mag_v;
  logic [DW-1:0] mag;
  lpd_isqrt #(.RW(DW)) u_root (
    .clk(clk), .rst(rst), .in_valid(energy_v), .in_x(energy_q),
    .out_valid(mag_v), .out_root(mag)
  );

  // bucket quantiser
  logic [SW-1:0] scaled, bucket;
  logic [AW-1:0] addr_nx, addr_q, addr_q2;
  logic          addr_v;
  assign scaled  = SW'(mag) * SW'(ENTRIES);
  assign bucket  = scaled >> (DW - 1);
  assign addr_nx = (bucket > SW'(ENTRIES - 1)) ? AW'(ENTRIES - 1) : bucket[AW-1:0];

  always_ff @(posedge clk) begin
    addr_v  <= rst ? 1'b0 : mag_v;
    addr_q  <= addr_nx;
    addr_q2 <= addr_q;
  end

  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    addr_v |-> (int'(addr_q) < ENTRIES));

  // gain table
  logic                 g_v;
  logic signed [GW-1:0] g_r, g_i;
  lpd_gain_table #(.GW(GW), .GF(GF), .ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_g_r(wr_gain_r), .wr_g_i(wr_gain_i),
    .rd_en(addr_v), .rd_addr(addr_q),
    .rd_valid(g_v), .rd_g_r(g_r), .rd_g_i(g_i)
  );

  // sample delay line matched to the table read
  logic signed [DW-1:0] dly_i [0:RD];
  logic signed [DW-1:0] dly_q [0:RD];
  always_ff @(posedge clk) begin
    dly_i[0] <= in_i;
    dly_q[0] <= in_q;
    for (int k = 1; k <= RD; k++) begin
      dly_i[k] <= dly_i[k-1];
      dly_q[k] <= dly_q[k-1];
    end
  end

  lpd_cmul #(.DW(DW), .GW(GW), .GF(GF), .AW(AW)) u_mul (
    .clk(clk), .rst(rst), .in_valid(g_v),
    .d_i(dly_i[RD]), .d_q(dly_q[RD]), .g_r(g_r), .g_i(g_i), .tag_addr(addr_q2),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .ref_i(ref_i), .ref_q(ref_q), .ref_addr(ref_addr)
  );
endmodule

// File: tb/lut_predistorter_bench.sv
`timescale 1ns/1ps
module lut_predistorter_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic signed [11:0] wr_gain_r = '0, wr_gain_i = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q, ref_i, ref_q;
  logic [6:0] ref_addr;

  always #4 clk = ~clk;

  lut_predistorter u_lut_predistorter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_gain_r(wr_gain_r), .wr_gain_i(wr_gain_i),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .ref_i(ref_i), .ref_q(ref_q), .ref_addr(ref_addr)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int mir_r [0:99];
  int mir_i [0:99];
  int q_oi[$], q_oq[$], q_ri[$], q_rq[$], q_ad[$], q_cy[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int ref_sqrt(input longint x);
    longint r = longint'($floor($sqrt(real'(x))));
    while (r * r > x) r--;
    while ((r + 1) * (r + 1) <= x) r++;
    return int'(r);
  endfunction

  function automatic int bucket_of(input int i, input int q);
    longint m = longint'(ref_sqrt(longint'(i) * i + longint'(q) * q));
    longint b = (m * 100) / 32768;
    return (b > 99) ? 99 : int'(b);
  endfunction

  function automatic int clamp16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic push_exp(input int i, input int q, input int gr, input int gi, input string tag);
    longint pr = longint'(i) * gr - longint'(q) * gi;
    longint pq = longint'(i) * gi + longint'(q) * gr;
    q_oi.push_back(clamp16((pr + 512) >>> 10));
    q_oq.push_back(clamp16((pq + 512) >>> 10));
    q_ri.push_back(i);
    q_rq.push_back(q);
    q_ad.push_back(bucket_of(i, q));
    q_cy.push_back(cyc + 20);
    q_tag.push_back(tag);
  endtask

  task automatic send_g(input int i, input int q, input int gr, input int gi, input string tag);
    push_exp(i, q, gr, gi, tag);
    in_valid = 1'b1;
    in_i = 16'(i);
    in_q = 16'(q);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send(input int i, input int q, input string tag);
    int a = bucket_of(i, q);
    send_g(i, q, mir_r[a], mir_i[a], tag);
  endtask

  task automatic tbl_write(input int a, input int gr, input int gi);
    wr_en = 1'b1;
    wr_addr = 7'(a);
    wr_gain_r = 12'(gr);
    wr_gain_i = 12'(gi);
    @(negedge clk);
    wr_en = 1'b0;
    mir_r[a] = gr;
    mir_i[a] = gi;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_oi.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: actual unexpected output expected none (cycle %0d)", cyc);
      end else begin
        string t = q_tag.pop_front();
        chk({t, " out_i"}, int'(out_i), q_oi.pop_front());
        chk({t, " out_q"}, int'(out_q), q_oq.pop_front());
        chk("R6 ref_i", int'(ref_i), q_ri.pop_front());
        chk("R6 ref_q", int'(ref_q), q_rq.pop_front());
        chk("R2 ref_addr", int'(ref_addr), q_ad.pop_front());
        chk("R5 latency", cyc, q_cy.pop_front());
      end
    end
  end

  function automatic int rand_s16(input int mode);
    int v = int'($signed(16'($urandom)));
    if (mode == 1) return v >>> 7;
    if (mode == 2) return ($urandom % 2) ? 32767 : -32768;
    return v;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R5: actual hung run expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20031));
    for (int a = 0; a < 100; a++) begin mir_r[a] = 1024; mir_i[a] = 0; end
    repeat (4) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);

    // R1: unity table passes samples unchanged
    send(1000, -2000, "R1");
    send(-12345, 321, "R1");
    send(0, 0, "R1");
    repeat (25) @(negedge clk);

    // R2: bucket edges and clamp
    send(327, 0, "R2");
    send(328, 0, "R2");
    send(0, 32767, "R2");
    send(-32768, 0, "R2");
    send(23170, 23170, "R2");
    send(-32768, -32768, "R2");
    repeat (25) @(negedge clk);

    // R4: both saturation rails through entry 99
    tbl_write(99, -1024, 0);
    send(-32768, 0, "R4");
    repeat (25) @(negedge clk);
    tbl_write(99, 2047, 0);
    send(-32768, 0, "R4");
    send(32767, -32768, "R4");
    repeat (25) @(negedge clk);

    // R7: write on the read edge (edge 18) is not seen
    send_g(16384, 0, mir_r[50], mir_i[50], "R7 same-edge");
    repeat (17) @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'd50; wr_gain_r = 12'sd512; wr_gain_i = 12'sd256;
    @(negedge clk);
    wr_en = 1'b0; mir_r[50] = 512; mir_i[50] = 256;
    repeat (25) @(negedge clk);
    // R7: write one edge earlier (edge 17) is seen
    send_g(16384, 0, 768, -256, "R7 prior-edge");
    repeat (16) @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'd50; wr_gain_r = 12'sd768; wr_gain_i = -12'sd256;
    @(negedge clk);
    wr_en = 1'b0; mir_r[50] = 768; mir_i[50] = -256;
    repeat (25) @(negedge clk);

    // R3: random table and gapped random stream
    for (int a = 0; a < 100; a++)
      tbl_write(a, int'($signed(12'($urandom))), int'($signed(12'($urandom))));
    for (int n = 0; n < 900; n++) begin
      if ($urandom % 4 != 0) begin
        int md = int'($urandom % 4);
        send(rand_s16(md), rand_s16(md), "R3");
      end else begin
        @(negedge clk);
      end
    end
    repeat (30) @(negedge clk);
    chk("R5 outstanding outputs", q_oi.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule